// File: doc/BRIEF.md
# Augmented Serial CRC Codec

This block computes a cyclic redundancy check one bit per cycle. It uses a small generator polynomial that is fixed by parameters. Every division step is a left shift of a partial remainder register. When the bit shifted out of the top is one, the low coefficients of the generator are XORed back in, because modulo-2 subtraction is plain XOR. A frame begins with a start pulse. The mode input, sampled only on that pulse, selects whether the frame is a message to encode or a codeword to check.

When encoding, the block takes the message MSB first and forwards each bit unchanged. It then divides the message as if degree-many zero bits had been appended to it. This takes degree-many internal cycles with no output. It then emits the remainder into the positions those zeros would have held. The codeword is therefore the original message followed by the check bits. For example, message 0xD6B5 with generator 1101 yields check bits 101 and codeword 0x6B5AD.

When checking, the block divides the whole received codeword and raises `ok` together with `done` only if the final remainder is zero. It forwards the message bits through a delay of degree-many accepted bits, so the trailing check bits never appear at the output.

Top module: `crc_serial_codec`

## Requirements
- R1: After reset, and while no frame is active, `dout_valid`, `done` and `ok` are low and `din_valid` produces no output.
- R2: A start pulse clears the remainder and begins a new frame. A start in the middle of a frame abandons that frame, and the new frame's result is unaffected.
- R3: In encode mode (`mode_chk`=0 at start), each accepted message bit appears unchanged on `dout` with `dout_valid` one cycle after it is accepted, MSB first.
- R4: In encode mode, after the last message bit there are exactly DEG cycles with `dout_valid` low while zeros are divided internally. `din` and `din_valid` are ignored from then until the frame ends.
- R5: In encode mode, DEG check bits follow MSB first and equal the remainder of (message × x^DEG) modulo the generator. The generator is {1, POLY_TAPS}, default 1101.
- R6: `done` is a one-cycle pulse. It coincides with the final output bit of the frame. In check mode that is one cycle after the last codeword bit is accepted.
- R7: In check mode, `ok` is high with `done` exactly when the codeword (MSG_BITS+DEG bits, MSB first) divides by the generator with zero remainder. `ok` is never high without `done`, and it stays low in encode mode.
- R8: In check mode, exactly the first MSG_BITS codeword bits are output. Each one appears one cycle after the codeword bit DEG positions later is accepted, so the DEG trailing check bits are never emitted.
- R9: Cycles with `din_valid` low pause the frame without changing its result.
- R10: The mode is latched at the start pulse. Changing `mode_chk` during a frame has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a new frame, clears the remainder |
| mode_chk | input | 1 | 0 = encode, 1 = check; sampled with start |
| din | input | 1 | Serial input bit, MSB first |
| din_valid | input | 1 | Qualifies din |
| dout | output | 1 | Serial output bit |
| dout_valid | output | 1 | Qualifies dout |
| done | output | 1 | One-cycle end-of-frame pulse |
| ok | output | 1 | Zero remainder in check mode, valid with done |

## Verification
The assertions take for granted that `start` is never high during reset and that a new frame is only started with a start pulse. They also assume that `din_valid` may be held high outside a frame, and they rely on the block to ignore it there. The stimulus respects these assumptions, and it deliberately holds `din_valid` high with random bits during the augmentation and tail cycles and after `done`. Between valid bits it inserts idle cycles carrying random data, and it toggles `mode_chk` right after every start. That way the ignored-input rules are exercised within what the assertions expect.

// File: rtl/crc_codec_pkg.sv
package crc_codec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_AUG   = 2'd2,
        ST_TAIL  = 2'd3
    } codec_state_e;

endpackage

// File: rtl/crc_div_step.sv
// One modulo-2 long-division step: bring down a bit, subtract the
// generator (XOR its low taps) when the shifted-out coefficient is one.
module crc_div_step #(
    parameter int             DEG  = 3,
    parameter logic [DEG-1:0] TAPS = 3'b101
) (
    input  logic [DEG-1:0] rem_i,
    input  logic           bit_i,
    output logic [DEG-1:0] rem_o
);
    logic top_bit;
    assign top_bit = rem_i[DEG-1];

    for (genvar k = 0; k < DEG; k++) begin : g_tap
        if (k == 0) begin : g_low
            assign rem_o[k] = bit_i ^ (top_bit & TAPS[k]);
        end else begin : g_up
            assign rem_o[k] = rem_i[k-1] ^ (top_bit & TAPS[k]);
        end
    end
endmodule

// File: rtl/crc_bit_delay.sv
// Delays accepted bits by DEPTH shift events; output is the oldest bit.
module crc_bit_delay #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic shift_en,
    input  logic bit_i,
    output logic bit_o
);
    logic [DEPTH-1:0] line_d, line_q;

    always_comb begin
        line_d = line_q;
        if (clear) begin
            line_d = '0;
        end else if (shift_en) begin
            line_d = {line_q[DEPTH-2:0], bit_i};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
        end else begin
            line_q <= line_d;
        end
    end

    assign bit_o = line_q[DEPTH-1];
endmodule

// File: rtl/crc_serial_codec.sv
module crc_serial_codec
    import crc_codec_pkg::*;
#(
    parameter int             MSG_BITS  = 16,
    parameter int             DEG       = 3,
    parameter logic [DEG-1:0] POLY_TAPS = 3'b101
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic mode_chk,
    input  logic din,
    input  logic din_valid,
    output logic dout,
    output logic dout_valid,
    output logic done,
    output logic ok
);
    localparam int CW_BITS = MSG_BITS + DEG;
    localparam int CNT_W   = $clog2(CW_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_MSG = CNT_W'(MSG_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_CW  = CNT_W'(CW_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_DEG = CNT_W'(DEG - 1);
    localparam logic [CNT_W-1:0] CNT_DEG  = CNT_W'(DEG);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        codec_state_e   state;
        logic           chk;
        logic [CNT_W-1:0] cnt;
        logic [DEG-1:0] rem;
        logic           dout;
        logic           dout_valid;
        logic           done;
        logic           ok;
    } codec_regs_t;

    codec_regs_t regs_d, regs_q;

    logic           div_bit;
    logic [DEG-1:0] div_rem;
    logic           dly_bit;
    logic           dly_shift;

    // During augmentation the divider is fed the implied zero bits.
    assign div_bit = (regs_q.state == ST_AUG) ? 1'b0 : din;

    crc_div_step #(
        .DEG  (DEG),
        .TAPS (POLY_TAPS)
    ) u_div (
        .rem_i (regs_q.rem),
        .bit_i (div_bit),
        .rem_o (div_rem)
    );

    assign dly_shift = !start && (regs_q.state == ST_SHIFT) && regs_q.chk && din_valid;

    crc_bit_delay #(
        .DEPTH (DEG)
    ) u_dly (
        .clk      (clk),
        .rst      (rst),
        .clear    (start),
        .shift_en (dly_shift),
        .bit_i    (din),
        .bit_o    (dly_bit)
    );

    always_comb begin
        regs_d            = regs_q;
        regs_d.dout_valid = 1'b0;
        regs_d.done       = 1'b0;
        regs_d.ok         = 1'b0;
        if (start) begin
            regs_d.state = ST_SHIFT;
            regs_d.chk   = mode_chk;
            regs_d.cnt   = '0;
            regs_d.rem   = '0;
        end else begin
            unique case (regs_q.state)
                ST_SHIFT: begin
                    if (din_valid) begin
                        regs_d.rem = div_rem;
                        regs_d.cnt = regs_q.cnt + CNT_ONE;
                        if (!regs_q.chk) begin
                            regs_d.dout       = din;
                            regs_d.dout_valid = 1'b1;
                            if (regs_q.cnt == LAST_MSG) begin
                                regs_d.state = ST_AUG;
                                regs_d.cnt   = '0;
                            end
                        end else begin
                            if (regs_q.cnt >= CNT_DEG) begin
                                regs_d.dout       = dly_bit;
                                regs_d.dout_valid = 1'b1;
                            end
                            if (regs_q.cnt == LAST_CW) begin
                                regs_d.state = ST_IDLE;
                                regs_d.done  = 1'b1;
                                regs_d.ok    = (div_rem == '0);
                            end
                        end
                    end
                end
                ST_AUG: begin
                    regs_d.rem = div_rem;
                    regs_d.cnt = regs_q.cnt + CNT_ONE;
                    if (regs_q.cnt == LAST_DEG) begin
                        regs_d.state = ST_TAIL;
                        regs_d.cnt   = '0;
                    end
                end
                ST_TAIL: begin
                    regs_d.dout       = regs_q.rem[DEG-1];
                    regs_d.dout_valid = 1'b1;
                    regs_d.rem        = {regs_q.rem[DEG-2:0], 1'b0};
                    regs_d.cnt        = regs_q.cnt + CNT_ONE;
                    if (regs_q.cnt == LAST_DEG) begin
                        regs_d.state = ST_IDLE;
                        regs_d.done  = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q       <= '0;
            regs_q.state <= ST_IDLE;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign dout       = regs_q.dout;
    assign dout_valid = regs_q.dout_valid;
    assign done       = regs_q.done;
    assign ok         = regs_q.ok;

    // ---------------- assertions ----------------
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (regs_q.state == ST_IDLE && !start) |=> (!dout_valid && !done));

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> (regs_q.rem == '0 && regs_q.cnt == '0));

    assert_aug_silent_R4: assert property (@(posedge clk) disable iff (rst)
        (regs_q.state == ST_AUG && !start) |=> !dout_valid);

    assert_tail_fills_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (regs_q.state == ST_TAIL && !start) |=> (regs_q.rem[0] == 1'b0));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_ok_needs_done_R7: assert property (@(posedge clk) disable iff (rst)
        ok |-> done);

    assert_check_bits_hidden_R8: assert property (@(posedge clk) disable iff (rst)
        (regs_q.state == ST_SHIFT && regs_q.chk && din_valid && !start
         && regs_q.cnt < CNT_DEG) |=> !dout_valid);
endmodule

// File: tb/sim_crc_serial_codec.sv
module sim_crc_serial_codec;
    localparam int MSG = 16;
    localparam int DG  = 3;
    localparam int CW  = MSG + DG;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, mode_chk = 1'b0, din = 1'b0, din_valid = 1'b0;
    logic dout, dout_valid, done, ok;

    always #4 clk = ~clk;  // 125 MHz

    crc_serial_codec u0 (
        .clk(clk), .rst(rst), .start(start), .mode_chk(mode_chk),
        .din(din), .din_valid(din_valid),
        .dout(dout), .dout_valid(dout_valid), .done(done), .ok(ok)
    );

    int n_checks = 0, n_errs = 0;
    int cyc = 0;
    logic [31:0] cap;
    int cap_n;
    int vidx[0:31];
    bit got_done, got_ok, done_prev;
    int done_idx;
    int first_drv, drv_deg, last_drv;

    // Remainder of an nbits-long polynomial modulo x^3+x^2+1.
    function automatic logic [2:0] poly_mod(logic [31:0] v, int nbits);
        for (int b = nbits - 1; b >= DG; b--)
            if (v[b]) v = v ^ (32'hD << (b - DG));
        return v[2:0];
    endfunction

    task automatic check(bit cond, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!cond) begin
            n_errs++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (dout_valid) begin
                if (cap_n < 32) vidx[cap_n] = cyc;
                cap = {cap[30:0], dout};
                cap_n++;
            end
            if (done) begin
                got_done = 1'b1; done_idx = cyc; got_ok = ok;
            end
            if (done && done_prev) check(1'b0, "R6", "done wider than one cycle", 1, 0);
            done_prev = done;
        end
        cyc++;
    end

    task automatic run_frame(bit m, logic [31:0] word, int nbits, bit gaps, bit junk);
        @(posedge clk); #2;
        cap = '0; cap_n = 0; got_done = 0; got_ok = 0;
        start = 1'b1; mode_chk = m; din_valid = 1'b0;
        @(posedge clk); #2;
        start = 1'b0; mode_chk = ~m;  // R10: mode change mid-frame ignored
        for (int i = 0; i < nbits; i++) begin
            if (gaps && (i % 3) == 1) begin  // R9 idle cycle with junk data
                din_valid = 1'b0; din = 1'($urandom);
                @(posedge clk); #2;
            end
            din = word[nbits-1-i]; din_valid = 1'b1;
            if (i == 0) first_drv = cyc;
            if (i == DG) drv_deg = cyc;
            last_drv = cyc;
            @(posedge clk); #2;
        end
        din_valid = junk;  // R4: junk during augmentation/tail
        for (int w = 0; w < 20 && !got_done; w++) begin
            din = 1'($urandom);
            @(posedge clk); #2;
        end
        din = 1'($urandom);
        @(posedge clk); #2;
        din_valid = 1'b0;
    endtask

    task automatic do_encode(logic [15:0] msg, bit gaps);
        logic [2:0]  crc;
        logic [18:0] exp;
        crc = poly_mod({13'd0, msg, 3'b000}, CW);
        exp = {msg, crc};
        run_frame(1'b0, {16'd0, msg}, MSG, gaps, 1'b1);
        check(cap_n == CW, "R3", "encode output count", cap_n, CW);
        check(cap[18:0] == exp, "R5", "codeword", cap[18:0], exp);
        check(got_done && done_idx == vidx[CW-1], "R6", "encode done position", done_idx, vidx[CW-1]);
        check(!got_ok, "R7", "ok in encode mode", got_ok, 0);
        if (!gaps) begin
            check(vidx[0] == first_drv + 1, "R3", "first bit latency", vidx[0], first_drv + 1);
            check(vidx[MSG] - vidx[MSG-1] == DG + 1, "R4", "augmentation gap",
                  vidx[MSG] - vidx[MSG-1], DG + 1);
        end
    endtask

    task automatic do_check(logic [18:0] cw, bit gaps);
        bit exp_ok;
        exp_ok = (poly_mod({13'd0, cw}, CW) == 3'd0);
        run_frame(1'b1, {13'd0, cw}, CW, gaps, 1'b0);
        check(cap_n == MSG, "R8", "check output count", cap_n, MSG);
        check(cap[15:0] == cw[18:3], "R8", "stripped message", cap[15:0], cw[18:3]);
        check(vidx[0] == drv_deg + 1, "R8", "forward delay", vidx[0], drv_deg + 1);
        check(got_done && done_idx == last_drv + 1, "R6", "check done position", done_idx, last_drv + 1);
        check(got_ok == exp_ok, "R7", "ok result", got_ok, exp_ok);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        logic [15:0] msg;
        logic [18:0] cw;
        cap = '0; cap_n = 0; got_done = 0; done_prev = 0;
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        // R1: no activity without a frame
        din_valid = 1'b1;
        repeat (6) begin din = 1'($urandom); @(posedge clk); #2; end
        din_valid = 1'b0;
        @(posedge clk); #2;
        check(cap_n == 0 && !got_done, "R1", "idle outputs", cap_n, 0);
        check(!dout_valid && !done && !ok, "R1", "reset state", {dout_valid, done, ok}, 0);

        // Worked example
        do_encode(16'hD6B5, 1'b0);
        check(cap[18:0] == 19'h6B5AD, "R5", "example codeword", cap[18:0], 19'h6B5AD);
        do_check(19'h6B5AD, 1'b0);
        check(got_ok, "R7", "example ok", got_ok, 1);
        do_check(19'h6B5AD ^ 19'h00400, 1'b0);
        check(!got_ok, "R7", "example flipped bit", got_ok, 0);

        // R2: abandon a frame mid-way then restart
        @(posedge clk); #2; start = 1'b1; mode_chk = 1'b0;
        @(posedge clk); #2; start = 1'b0; din_valid = 1'b1;
        repeat (7) begin din = 1'($urandom); @(posedge clk); #2; end
        din_valid = 1'b0;
        do_encode(16'h1234, 1'b0);
        check(cap[18:0] == {16'h1234, poly_mod({13'd0, 16'h1234, 3'b000}, CW)},
              "R2", "result after restart", cap[18:0], 0);

        // Sweep
        for (int i = 0; i < 900; i++) begin
            msg = 16'(i * 4099 + 16'h1357);
            if (i == 1) msg = 16'h0000;
            if (i == 2) msg = 16'hFFFF;
            if (i == 3) msg = 16'h8000;
            if (i == 4) msg = 16'h0001;
            do_encode(msg, (i % 5) == 0);
            cw = {msg, poly_mod({13'd0, msg, 3'b000}, CW)};
            do_check(cw, (i % 7) == 0);
            do_check(cw ^ (19'd1 << (i % CW)), (i % 4) == 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule